// File: doc/BRIEF.md
# Banked Interrupt Request Controller

This block collects peripheral interrupt request lines and presents them to a processor as one interrupt output per bank. Sources are grouped in banks of 32. Each bank has its own set of memory-mapped registers. Each source can be configured as level- or edge-sensitive, and as active-high or active-low. Requests that are pending and enabled raise the bank's processor line. Software acknowledges a latched request by writing ones to that bank's clear register.

Every request line first passes through a two-flop synchroniser. In edge mode, a latch then holds the request until software clears it. In level mode, the request follows the synchronised line, adjusted for polarity. A software set register can force any source pending, so the block can raise software-triggered interrupts. Each bank also has a read-only register that reports the lowest-numbered source that is both pending and enabled, so the interrupt handler needs no bit scan.

Source number n belongs to bank n/32 and sits at bit position n%32 of that bank. The processor line for bank b is bit b of `cpu_irq_o`.

Top module: `intc_banked`

## Requirements
- R1: Bank b's registers start at byte address 24*b. Within a bank, the offsets are: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10 and edge-select 0x14. Enable, polarity and edge-select read back the value last written.
- R2: After reset, the enable, polarity and edge-select registers and all latched pending bits are 0, and `cpu_irq_o` is 0.
- R3: `cpu_irq_o[b]` is 1 exactly when the status and enable registers of bank b share a set bit.
- R4: Writing the clear register removes the latched pending state of each source whose written bit is 1. Bits written as 0 leave their sources untouched. In level mode, a source whose input is still active stays visible in status.
- R5: When edge-select is 1, a source latches pending on a rising input edge if polarity is 1, and on a falling edge if polarity is 0. The bit appears in status on the third rising clock edge after the input changes, and it stays set until cleared. If an edge event and a clear of the same bit fall in the same cycle, the event wins.
- R6: When edge-select is 0, the status bit equals the input if polarity is 1, and the inverted input if polarity is 0. An input change shows in status after two rising clock edges, and a polarity write takes effect right after the write edge.
- R7: Writing the set register forces each source whose written bit is 1 to pending, in either mode, until that source is cleared. The set and clear registers read as 0.
- R8: The read-only register at byte address 0x60+4*b reports the lowest pending-and-enabled source of bank b. Bit 31 is the valid flag and bits 4:0 hold the bit position. The register reads 0 when bank b has no such source.
- R9: Reads of addresses outside the register map, or of addresses that are not word-aligned, return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Peripheral request lines, source n at bit n |
| bus_addr_i | input | 8 | Byte address for register access |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| cpu_irq_o | output | 4 | One processor interrupt line per bank |

## Verification
Level-mode sources are driven active-high and active-low. This separates how polarity acts on a level source from the two-cycle synchroniser latency, which is checked one cycle early and one cycle on time. Edge sources are tested in two ways:
- A pulse checks that the pending bit stays set after the input falls.
- A wrong-direction transition checks that the edge decoder does not react to it.

Clears written with mixed bit patterns show that only the selected bits drop. Sources in different banks show that the bank-to-line mapping is correct. Several pending sources are raised at once to show that the lowest-position report takes the lowest one.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = $clog2(REG_W);
  localparam int unsigned N_REGS  = 6;
  localparam int unsigned STRIDE  = N_REGS * 4;

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_EN   = 3'd1,
    SEL_SET  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_POL  = 3'd4,
    SEL_EDGE = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } first_t;

  // Level request after polarity: pol=1 active high, pol=0 active low.
  function automatic logic [REG_W-1:0] level_req(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] pol);
    return ~(cur ^ pol);
  endfunction

  // Edge event on the raw synchronised line, so polarity writes make no edge.
  function automatic logic [REG_W-1:0] edge_evt(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] prev,
                                                input logic [REG_W-1:0] pol);
    return (cur & ~prev & pol) | (~cur & prev & ~pol);
  endfunction

  function automatic first_t find_first(input logic [REG_W-1:0] v);
    first_t r;
    r = '0;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.valid = 1'b1;
        r.idx   = IDX_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_first.sv
module intc_first
  import intc_pkg::*;
(
  input  logic [REG_W-1:0] pend_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  first_t f;
  assign f       = find_first(pend_i);
  assign valid_o = f.valid;
  assign idx_o   = f.idx;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  sync_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  enable_o,
  output logic [REG_W-1:0]  edgesel_o,
  output logic [REG_W-1:0]  event_o,
  output logic [REG_W-1:0]  set_o,
  output logic [REG_W-1:0]  clr_o,
  output logic [REG_W-1:0]  pend_o
);
  logic [ADDR_W:0]  diff;
  logic             hit;
  reg_sel_e         sel;
  logic [REG_W-1:0] en_q, pol_q, edge_q, latch_q, prev_q;
  logic [REG_W-1:0] status;

  assign diff = {1'b0, addr_i} - (ADDR_W+1)'(BASE);
  assign hit  = !diff[ADDR_W] && (diff[ADDR_W-1:0] < ADDR_W'(STRIDE)) &&
                (diff[1:0] == 2'b00);
  assign sel  = reg_sel_e'(diff[4:2]);

  assign set_o   = (we_i && hit && sel == SEL_SET) ? wdata_i : '0;
  assign clr_o   = (we_i && hit && sel == SEL_CLR) ? wdata_i : '0;
  assign event_o = edge_evt(sync_i, prev_q, pol_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      latch_q <= '0;
      prev_q  <= '0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= (latch_q & ~clr_o) | set_o | (event_o & edge_q);
      if (we_i && hit && sel == SEL_EN)   en_q   <= wdata_i;
      if (we_i && hit && sel == SEL_POL)  pol_q  <= wdata_i;
      if (we_i && hit && sel == SEL_EDGE) edge_q <= wdata_i;
    end
  end

  assign status    = latch_q | (~edge_q & level_req(sync_i, pol_q));
  assign status_o  = status;
  assign enable_o  = en_q;
  assign edgesel_o = edge_q;
  assign pend_o    = status & en_q;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (sel)
        SEL_STAT: rdata_o = status;
        SEL_EN:   rdata_o = en_q;
        SEL_POL:  rdata_o = pol_q;
        SEL_EDGE: rdata_o = edge_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
  import intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS*REG_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]            bus_addr_i,
  input  logic                         bus_we_i,
  input  logic [REG_W-1:0]             bus_wdata_i,
  output logic [REG_W-1:0]             bus_rdata_o,
  output logic [NUM_BANKS-1:0]         cpu_irq_o
);
  localparam int unsigned NUM_SRC    = NUM_BANKS * REG_W;
  localparam int unsigned FIRST_BASE = NUM_BANKS * STRIDE;

  logic [NUM_SRC-1:0] sync_all, status_all, enable_all, edgesel_all;
  logic [NUM_SRC-1:0] event_all, set_all, clr_all, pend_all;
  logic [REG_W-1:0]   bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] first_valid;
  logic [IDX_W-1:0]   first_idx [NUM_BANKS];

  intc_sync #(.W(NUM_SRC)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(sync_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank #(.ADDR_W(ADDR_W), .BASE(b * STRIDE)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .sync_i(sync_all[b*REG_W +: REG_W]),
      .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
      .rdata_o(bank_rd[b]),
      .status_o(status_all[b*REG_W +: REG_W]),
      .enable_o(enable_all[b*REG_W +: REG_W]),
      .edgesel_o(edgesel_all[b*REG_W +: REG_W]),
      .event_o(event_all[b*REG_W +: REG_W]),
      .set_o(set_all[b*REG_W +: REG_W]),
      .clr_o(clr_all[b*REG_W +: REG_W]),
      .pend_o(pend_all[b*REG_W +: REG_W])
    );
    intc_first first_i (
      .pend_i(pend_all[b*REG_W +: REG_W]),
      .valid_o(first_valid[b]),
      .idx_o(first_idx[b])
    );
    assign cpu_irq_o[b] = |pend_all[b*REG_W +: REG_W];
  end

  logic [ADDR_W:0] fdiff;
  logic            fhit;
  assign fdiff = {1'b0, bus_addr_i} - (ADDR_W+1)'(FIRST_BASE);
  assign fhit  = !fdiff[ADDR_W] && (fdiff[ADDR_W-1:0] < ADDR_W'(4 * NUM_BANKS)) &&
                 (fdiff[1:0] == 2'b00);

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bus_rdata_o = bus_rdata_o | bank_rd[b];
      if (fhit && fdiff[ADDR_W-1:2] == (ADDR_W-1)'(b))
        bus_rdata_o = bus_rdata_o |
                      {first_valid[b], {(REG_W-1-IDX_W){1'b0}}, first_idx[b]};
    end
  end
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk #(
  parameter int unsigned NUM_SRC   = 128,
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] irq,
  input logic [NUM_BANKS-1:0] first_valid,
  input logic [NUM_SRC-1:0]   status,
  input logic [NUM_SRC-1:0]   enable,
  input logic [NUM_SRC-1:0]   edgesel,
  input logic [NUM_SRC-1:0]   evt,
  input logic [NUM_SRC-1:0]   setv,
  input logic [NUM_SRC-1:0]   clrv
);
  p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |-> (irq == '0));

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clrv & edgesel & ~evt)) |=> ((status & $past(clrv & edgesel & ~evt)) == '0));

  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & edgesel)) |=> ((status & $past(evt & edgesel)) == $past(evt & edgesel)));

  p_set_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|setv) |=> ((status & $past(setv)) == $past(setv)));

  p_first_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid == irq);
endmodule

bind intc_banked intc_banked_chk #(.NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(cpu_irq_o), .first_valid(first_valid),
  .status(status_all), .enable(enable_all), .edgesel(edgesel_all),
  .evt(event_all), .setv(set_all), .clrv(clr_all)
);

// File: tb/intc_banked_tb.sv
`timescale 1ns/1ps
module intc_banked_tb_top;
  localparam int NB = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*32-1:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NB-1:0] irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] q_exp[$];
  bit          q_irq[$];
  string       q_tag[$];
  event        smp_ev;

  always #2.5 clk = ~clk;

  intc_banked dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cpu_irq_o(irq)
  );

  function automatic logic [7:0] ra(int bank, int off);
    return 8'(24 * bank + off);
  endfunction

  // Monitor: pops expected items and compares with the ports.
  initial forever begin
    @(smp_ev);
    while (q_exp.size() > 0) begin
      logic [31:0] e, a;
      bit k;
      string t;
      e = q_exp.pop_front(); k = q_irq.pop_front(); t = q_tag.pop_front();
      a = k ? 32'(irq) : rdata;
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic exp_rd(logic [7:0] a, logic [31:0] e, string t);
    addr = a; #0.5;
    q_exp.push_back(e); q_irq.push_back(1'b0); q_tag.push_back(t);
    -> smp_ev; #0.5;
  endtask

  task automatic exp_irq(logic [NB-1:0] e, string t);
    #0.5;
    q_exp.push_back(32'(e)); q_irq.push_back(1'b1); q_tag.push_back(t);
    -> smp_ev; #0.5;
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ticks(3); rst_n = 1'b1; ticks(1);
    // R2: reset state
    exp_rd(ra(0, 4), 32'h0, "R2 enable reset");
    exp_rd(ra(0, 16), 32'h0, "R2 polarity reset");
    exp_rd(ra(0, 20), 32'h0, "R2 edge reset");
    exp_irq('0, "R2 irq reset");
    // R6: active-low level with inputs low shows all pending
    exp_rd(ra(0, 0), 32'hFFFF_FFFF, "R6 active-low level after reset");
    // software configuration: active-high level everywhere
    for (int b = 0; b < NB; b++) begin
      wr(ra(b, 12), 32'hFFFF_FFFF);
      wr(ra(b, 16), 32'hFFFF_FFFF);
      wr(ra(b, 20), 32'h0);
    end
    exp_rd(ra(2, 16), 32'hFFFF_FFFF, "R1 polarity readback bank2");
    exp_rd(ra(0, 0), 32'h0, "R6 active-high idle");
    // R6 latency: two edges
    @(negedge clk); src[5] = 1'b1;
    ticks(1); exp_rd(ra(0, 0), 32'h0, "R6 one edge not yet");
    ticks(1); exp_rd(ra(0, 0), 32'h20, "R6 two edges visible");
    exp_irq('0, "R3 disabled no irq");
    wr(ra(0, 4), 32'hFFFF_FFFF);
    exp_irq(4'b0001, "R3 bank0 line");
    exp_rd(8'h60, 32'h8000_0005, "R8 single source");
    src[3] = 1'b1; ticks(2);
    exp_rd(8'h60, 32'h8000_0003, "R8 lowest wins");
    wr(ra(0, 12), 32'h20);
    exp_rd(ra(0, 0), 32'h28, "R4 level active survives clear");
    src[3] = 1'b0; src[5] = 1'b0; ticks(2);
    exp_irq('0, "R3 level dropped");
    exp_rd(8'h60, 32'h0, "R8 none pending");
    // R6 active-low on bank1, R3 mapping
    wr(ra(1, 16), 32'hFFFF_FF7F);
    exp_rd(ra(1, 0), 32'h80, "R6 active-low bank1");
    wr(ra(1, 4), 32'h80);
    exp_irq(4'b0010, "R3 bank1 line");
    wr(ra(1, 16), 32'hFFFF_FFFF);
    exp_irq('0, "R3 bank1 released");
    // R5 rising edge bank2 bit0
    wr(ra(2, 20), 32'h1);
    @(negedge clk); src[64] = 1'b1;
    ticks(2); exp_rd(ra(2, 0), 32'h0, "R5 two edges not yet");
    ticks(1); exp_rd(ra(2, 0), 32'h1, "R5 third edge latched");
    src[64] = 1'b0; ticks(4);
    exp_rd(ra(2, 0), 32'h1, "R5 sticky after fall");
    wr(ra(2, 12), 32'hFFFF_FFFE);
    exp_rd(ra(2, 0), 32'h1, "R4 zero bit no effect");
    wr(ra(2, 12), 32'h1);
    exp_rd(ra(2, 0), 32'h0, "R4 clear removes");
    // R5 falling edge bank2 bit1
    wr(ra(2, 20), 32'h3);
    wr(ra(2, 16), 32'hFFFF_FFFD);
    exp_rd(ra(2, 0), 32'h0, "R5 polarity write no edge");
    src[65] = 1'b1; ticks(4);
    exp_rd(ra(2, 0), 32'h0, "R5 rising ignored for falling");
    src[65] = 1'b0; ticks(4);
    exp_rd(ra(2, 0), 32'h2, "R5 falling latched");
    exp_irq('0, "R3 bank2 disabled");
    wr(ra(2, 12), 32'h2);
    // R7 software set bank3
    wr(ra(3, 8), 32'h0001_0000);
    exp_rd(ra(3, 0), 32'h0001_0000, "R7 set forces pending");
    exp_rd(ra(3, 8), 32'h0, "R7 set reads zero");
    exp_rd(ra(3, 12), 32'h0, "R7 clear reads zero");
    wr(ra(3, 4), 32'h0001_0000);
    exp_irq(4'b1000, "R3 bank3 line");
    exp_rd(8'h6C, 32'h8000_0010, "R8 bank3 index");
    wr(ra(3, 12), 32'h0001_0000);
    exp_irq('0, "R4 bank3 cleared");
    // R9 unmapped and misaligned
    exp_rd(8'h70, 32'h0, "R9 unmapped read");
    wr(8'h74, 32'h1234_5678);
    wr(8'h05, 32'h0);
    exp_rd(ra(0, 4), 32'hFFFF_FFFF, "R9 enable untouched");
    exp_rd(8'h06, 32'h0, "R9 misaligned read");
    ticks(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule